// File: doc/BRIEF.md
# Four-Lane Receive Deskew Buffer

The block sits behind four decoded receive lanes. It brings lanes that reach it with different delays back into a common column. Every lane passes through its own eight-entry elastic buffer, and each entry holds one 10-bit word: an error flag, a control flag and an 8-bit character. A per-lane read delay selects which entry leaves the buffer. When every lane has shown an alignment marker within the span of the buffer, the delays are rewritten so that all four markers leave in the same clock cycle.

The marker can be either of two things, chosen by an input. The first is the align control character. The second is the first non-idle character after a run of idles. In the second case lane 0 must carry the packet start character. There are two alignment modes. In the plain mode the delays are reloaded on every complete marker column. In the hysteresis mode, alignment is declared only after several consistent columns, and it is given up only after several bad ones.

The block also raises a one-cycle error pulse when the lanes are skewed by more than the buffer can absorb. It stays out of alignment while decoding is off, while the lane rate settings differ, or while any lane reports loss of signal or sync.

Top module: `lane_deskew`

## Requirements
- R1: While reset is asserted, every lane output is zero and both `aligned` and `deskewErr` are low.
- R2: Each lane word is {error flag, control flag, 8-bit character}. Lane output i equals lane input i delayed by d_i+1 clock cycles. The per-lane delay d_i lies in 0..7 and is 0 after reset.
- R3: With `markSel`=0 the marker is the align character: control flag 1, character 0x7C. Consider the cycle in which the last lane's marker arrives while every lane has had a marker within the last 8 cycles. In that cycle each d_i is set to the age in cycles of that lane's marker, so all four markers leave together one cycle later.
- R4: With `markSel`=1 the marker is a non-idle word that follows an idle word on the same lane. Idle means control flag 1 with character 0xBC, 0x7C or 0x1C. On lane 0, only the start character counts as a marker: control flag 1, character 0xFB.
- R5: With `calEn`=1 and `smEn`=0, every complete marker column reloads the delays at once and sets `aligned`.
- R6: With `smEn`=1, `calEn` has no effect. `aligned` rises only after 4 consecutive complete columns, all consistent with the current delays; the first of these may load new delays.
- R7: With `smEn`=1 and `aligned` high, a column that disagrees with the delays does not reload them. 4 bad columns (disagreeing columns or deskew errors) without 4 good columns in between clear `aligned`.
- R8: If a lane's marker reaches 8 cycles of age without having formed a complete column, `deskewErr` pulses for one cycle and the delays stay unchanged. In plain mode `aligned` is also cleared.
- R9: If any bit of `laneOk` is low, `aligned` is low in the next cycle and no delay is reloaded.
- R10: If `codecOn` is low, or if the four `laneRate` bits are not all equal, no alignment takes place and `aligned` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common receive clock |
| rstN | input | 1 | Asynchronous reset, active low |
| laneIn | input | 4x10 | Decoded words per lane: [9] error, [8] control, [7:0] character |
| codecOn | input | 1 | Decoding active; deskew allowed only when high |
| laneRate | input | 4 | Per-lane rate setting; must all be equal |
| laneOk | input | 4 | Per-lane signal and sync good |
| calEn | input | 1 | Plain alignment enable (no hysteresis) |
| smEn | input | 1 | Hysteresis alignment mode; overrides calEn |
| markSel | input | 1 | 0: align character marker, 1: idle-to-data marker |
| laneOut | output | 4x10 | Aligned words per lane |
| aligned | output | 1 | Lanes aligned |
| deskewErr | output | 1 | One-cycle pulse: skew beyond the buffer span |

## Verification
A complete marker column and a change of lane health can fall in the same cycle. When that happens the column must neither reload the delays nor raise `aligned`. The bench provokes this by dropping a lane's health flag while marker columns are flowing. A behavioural model ages each lane's marker and decides on events and counter moves from the requirements; it is compared with every output on every clock. The hysteresis counters are also pushed into the case where a skew change yields disagreeing columns while the block is already aligned, and the bench judges whether the delays hold and how many columns pass before `aligned` falls and returns.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  parameter int DSK_LANES = 4;
  parameter int DSK_DEPTH = 8;
  parameter int DSK_HYST  = 4;
  localparam int DSK_CW = 10;
  localparam int DSK_PW = $clog2(DSK_DEPTH);
  localparam int DSK_AW = $clog2(DSK_DEPTH + 1);
  localparam int DSK_HW = $clog2(DSK_HYST + 1);
  localparam logic [7:0] CH_SYNC  = 8'hBC;
  localparam logic [7:0] CH_ALIGN = 8'h7C;
  localparam logic [7:0] CH_SKIP  = 8'h1C;
  localparam logic [7:0] CH_START = 8'hFB;

  typedef struct packed {
    logic                              load;
    logic [DSK_LANES-1:0][DSK_PW-1:0]  delay;
  } dskStrobe_t;
endpackage

// File: rtl/deskew_buf.sv
module deskew_buf
  import deskew_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [DSK_LANES-1:0][DSK_CW-1:0]  laneIn,
  input  logic                              markSel,
  input  dskStrobe_t                        strb,
  output logic [DSK_LANES-1:0]              markOut,
  output logic [DSK_LANES-1:0][DSK_PW-1:0]  curDelay,
  output logic [DSK_LANES-1:0][DSK_CW-1:0]  laneOut
);
  logic [DSK_PW-1:0] wrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPtr <= '0;
    else       wrPtr <= wrPtr + 1'b1;
  end

  for (genvar g = 0; g < DSK_LANES; g++) begin : gLane
    logic [DSK_CW-1:0] mem [DSK_DEPTH];
    logic [DSK_CW-1:0] outQ;
    logic              prevIdle;
    logic [DSK_PW-1:0] dly;
    logic [DSK_PW-1:0] rdPtr;
    logic              isIdle, isAlign, startOk;

    always_comb begin
      isIdle  = laneIn[g][8] && (laneIn[g][7:0] == CH_SYNC ||
                laneIn[g][7:0] == CH_ALIGN || laneIn[g][7:0] == CH_SKIP);
      isAlign = laneIn[g][8] && (laneIn[g][7:0] == CH_ALIGN);
      startOk = (g == 0) ? (laneIn[g][8] && laneIn[g][7:0] == CH_START) : !isIdle;
      rdPtr   = wrPtr - dly - 1'b1;
    end

    assign markOut[g]  = markSel ? (prevIdle && startOk) : isAlign;
    assign curDelay[g] = dly;
    assign laneOut[g]  = outQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < DSK_DEPTH; k++) mem[k] <= '0;
        prevIdle <= 1'b0;
        dly      <= '0;
        outQ     <= '0;
      end else begin
        mem[wrPtr] <= laneIn[g];
        prevIdle   <= isIdle;
        outQ       <= mem[rdPtr];
        if (strb.load) dly <= strb.delay[g];
      end
    end
  end

  // R2
  delay_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (curDelay == $past(strb.delay)));

  // R2
  delay_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(curDelay));
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
  import deskew_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [DSK_LANES-1:0]              markIn,
  input  logic [DSK_LANES-1:0][DSK_PW-1:0]  curDelay,
  input  logic                              codecOn,
  input  logic [DSK_LANES-1:0]              laneRate,
  input  logic [DSK_LANES-1:0]              laneOk,
  input  logic                              calEn,
  input  logic                              smEn,
  output dskStrobe_t                        strb,
  output logic                              aligned,
  output logic                              deskewErr
);
  logic [DSK_LANES-1:0][DSK_AW-1:0] age, nAge;
  logic [DSK_LANES-1:0] used, near, expire;
  logic [DSK_HW-1:0] goodCnt, badCnt;
  logic allow, active, fault, okRun, colEv, colMatch, errEv;

  always_comb begin
    allow    = codecOn && (laneRate == '0 || laneRate == '1);
    active   = allow && (smEn || calEn);
    fault    = !(&laneOk);
    okRun    = active && !fault;
    colMatch = 1'b1;
    for (int i = 0; i < DSK_LANES; i++) begin
      if (markIn[i])                            nAge[i] = '0;
      else if (age[i] >= DSK_AW'(DSK_DEPTH))    nAge[i] = DSK_AW'(DSK_DEPTH);
      else                                      nAge[i] = age[i] + 1'b1;
      near[i]   = nAge[i] < DSK_AW'(DSK_DEPTH);
      expire[i] = (age[i] == DSK_AW'(DSK_DEPTH - 1)) && !markIn[i] && !used[i];
      if (curDelay[i] != nAge[i][DSK_PW-1:0]) colMatch = 1'b0;
      strb.delay[i] = nAge[i][DSK_PW-1:0];
    end
    colEv     = active && (|markIn) && (&near);
    errEv     = active && (|expire);
    strb.load = okRun && colEv && (!smEn || (!aligned && !colMatch));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      age       <= {DSK_LANES{DSK_AW'(DSK_DEPTH)}};
      used      <= '0;
      deskewErr <= 1'b0;
    end else begin
      age       <= nAge;
      deskewErr <= errEv;
      for (int i = 0; i < DSK_LANES; i++) begin
        if (colEv)          used[i] <= 1'b1;
        else if (markIn[i]) used[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aligned <= 1'b0;
      goodCnt <= '0;
      badCnt  <= '0;
    end else if (!okRun) begin
      aligned <= 1'b0;
      goodCnt <= '0;
      badCnt  <= '0;
    end else if (!smEn) begin
      goodCnt <= '0;
      badCnt  <= '0;
      if (colEv)      aligned <= 1'b1;
      else if (errEv) aligned <= 1'b0;
    end else if (!aligned) begin
      badCnt <= '0;
      if (colEv) begin
        if (!colMatch) goodCnt <= DSK_HW'(1);
        else if (goodCnt == DSK_HW'(DSK_HYST - 1)) begin
          aligned <= 1'b1;
          goodCnt <= '0;
        end else goodCnt <= goodCnt + 1'b1;
      end else if (errEv) goodCnt <= '0;
    end else begin
      if (colEv && colMatch) begin
        if (goodCnt == DSK_HW'(DSK_HYST - 1)) begin
          goodCnt <= '0;
          badCnt  <= '0;
        end else goodCnt <= goodCnt + 1'b1;
      end else if (colEv || errEv) begin
        goodCnt <= '0;
        if (badCnt == DSK_HW'(DSK_HYST - 1)) begin
          aligned <= 1'b0;
          badCnt  <= '0;
        end else badCnt <= badCnt + 1'b1;
      end
    end
  end

  // R9
  fault_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(&laneOk) |=> !aligned);

  // R10
  codec_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !codecOn |=> !aligned);

  // R6
  rise_on_column_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aligned) |-> $past(colEv));

  // R8
  err_clears_plain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deskewErr && $past(!smEn)) |-> !aligned);

  // R7
  hyst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(smEn && aligned) |-> $stable(curDelay));
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
  import deskew_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [DSK_LANES-1:0][DSK_CW-1:0]  laneIn,
  input  logic                              codecOn,
  input  logic [DSK_LANES-1:0]              laneRate,
  input  logic [DSK_LANES-1:0]              laneOk,
  input  logic                              calEn,
  input  logic                              smEn,
  input  logic                              markSel,
  output logic [DSK_LANES-1:0][DSK_CW-1:0]  laneOut,
  output logic                              aligned,
  output logic                              deskewErr
);
  dskStrobe_t                       strb;
  logic [DSK_LANES-1:0]             markW;
  logic [DSK_LANES-1:0][DSK_PW-1:0] curDelayW;

  deskew_buf uBuf (
    .clk      (clk),
    .rstN     (rstN),
    .laneIn   (laneIn),
    .markSel  (markSel),
    .strb     (strb),
    .markOut  (markW),
    .curDelay (curDelayW),
    .laneOut  (laneOut)
  );

  deskew_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .markIn    (markW),
    .curDelay  (curDelayW),
    .codecOn   (codecOn),
    .laneRate  (laneRate),
    .laneOk    (laneOk),
    .calEn     (calEn),
    .smEn      (smEn),
    .strb      (strb),
    .aligned   (aligned),
    .deskewErr (deskewErr)
  );
endmodule

// File: tb/lane_deskew_test.sv
module lane_deskew_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0][9:0] laneIn = '0;
  logic codecOn = 1'b1;
  logic [3:0] laneRate = 4'h0;
  logic [3:0] laneOk = 4'hF;
  logic calEn = 1'b1, smEn = 1'b0, markSel = 1'b0;
  logic [3:0][9:0] laneOut;
  logic aligned, deskewErr;

  lane_deskew uut (.clk(clk), .rstN(rstN), .laneIn(laneIn), .codecOn(codecOn),
    .laneRate(laneRate), .laneOk(laneOk), .calEn(calEn), .smEn(smEn),
    .markSel(markSel), .laneOut(laneOut), .aligned(aligned), .deskewErr(deskewErr));

  always #10 clk = ~clk;

  int nChk = 0, nFail = 0, wd = 0;
  int tGen = 0, genMode = 0;
  int skew [4] = '{0, 2, 5, 3};
  string alTag = "R5";
  int aCols = 0, sCols = 0, errPulses = 0, falls = 0;
  logic prevAl = 1'b0;

  // behavioural reference
  logic [9:0] mHist [4][16];
  logic [9:0] mOut [4];
  int mAge [4], mDly [4], nA [4];
  bit mUsed [4], mPrevIdle [4], mk [4];
  bit mAl = 0, mErr = 0;
  int mGood = 0, mBad = 0, cyc = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] genChar(int md, int lane, int c);
    int p;
    if (c < 0) return {2'b01, 8'hBC};
    p = c % 32;
    if (md == 0) begin
      if (p == 0) return {2'b01, 8'h7C};
      if (p >= 10 && p <= 13) return {(p == 11), 1'b0, 8'(c * 7 + lane)};
      return {2'b01, 8'hBC};
    end
    if (p == 4) return (lane == 0) ? {2'b01, 8'hFB} : {2'b00, 8'(c + lane)};
    if (p > 4 && p < 10) return {2'b00, 8'(c * 3 + lane)};
    if (p == 10 && lane == 0) return {2'b01, 8'hFD};
    return {2'b01, 8'hBC};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        for (int k = 0; k < 16; k++) mHist[i][k] = '0;
        mOut[i] = '0; mAge[i] = 8; mDly[i] = 0; mUsed[i] = 0; mPrevIdle[i] = 0;
      end
      mAl = 0; mErr = 0; mGood = 0; mBad = 0; cyc = 0;
    end else begin
      bit anyMk, allNear, match, ev, expire, act, okRun, load;
      anyMk = 0; allNear = 1; match = 1; expire = 0;
      for (int i = 0; i < 4; i++) begin
        bit idle, start;
        logic [9:0] w;
        w = laneIn[i];
        mOut[i] = mHist[i][(cyc - mDly[i] - 1) & 15];
        idle = w[8] && (w[7:0] == 8'hBC || w[7:0] == 8'h7C || w[7:0] == 8'h1C);
        start = (i == 0) ? (w[8] && w[7:0] == 8'hFB) : !idle;
        mk[i] = markSel ? (mPrevIdle[i] && start) : (w[8] && w[7:0] == 8'h7C);
        mPrevIdle[i] = idle;
        nA[i] = mk[i] ? 0 : (mAge[i] >= 8 ? 8 : mAge[i] + 1);
        if (mk[i]) anyMk = 1;
        if (nA[i] > 7) allNear = 0;
        if (mDly[i] != (nA[i] & 7)) match = 0;
        if (mAge[i] == 7 && !mk[i] && !mUsed[i]) expire = 1;
      end
      act = codecOn && (laneRate == 4'h0 || laneRate == 4'hF) && (smEn || calEn);
      okRun = act && (laneOk == 4'hF);
      ev = act && anyMk && allNear;
      expire = act && expire;
      load = okRun && ev && (!smEn || (!mAl && !match));
      if (!okRun) begin mAl = 0; mGood = 0; mBad = 0; end
      else if (!smEn) begin
        mGood = 0; mBad = 0;
        if (ev) mAl = 1; else if (expire) mAl = 0;
      end else if (!mAl) begin
        mBad = 0;
        if (ev) begin
          if (!match) mGood = 1;
          else if (mGood == 3) begin mAl = 1; mGood = 0; end
          else mGood++;
        end else if (expire) mGood = 0;
      end else begin
        if (ev && match) begin
          if (mGood == 3) begin mGood = 0; mBad = 0; end else mGood++;
        end else if (ev || expire) begin
          mGood = 0;
          if (mBad == 3) begin mAl = 0; mBad = 0; end else mBad++;
        end
      end
      mErr = expire;
      for (int i = 0; i < 4; i++) begin
        if (load) mDly[i] = nA[i] & 7;
        if (ev) mUsed[i] = 1; else if (mk[i]) mUsed[i] = 0;
        mAge[i] = nA[i];
        mHist[i][cyc & 15] = laneIn[i];
      end
      cyc++;
    end
  end

  // compare every clock, then drive next column
  always @(negedge clk) begin
    if (rstN) begin
      bit allA, sCol;
      allA = 1; sCol = (laneOut[0] == {2'b01, 8'hFB});
      for (int i = 0; i < 4; i++) begin
        check(laneOut[i] === mOut[i], "R2", $sformatf("lane %0d word", i), laneOut[i], mOut[i]);
        if (laneOut[i] != {2'b01, 8'h7C}) allA = 0;
        if (i > 0 && laneOut[i][8]) sCol = 0;
      end
      check(aligned === mAl, alTag, "aligned", aligned, mAl);
      check(deskewErr === mErr, "R8", "deskewErr", deskewErr, mErr);
      if (allA) aCols++;
      if (sCol) sCols++;
      if (deskewErr) errPulses++;
      if (prevAl && !aligned) falls++;
      prevAl = aligned;
    end
    for (int i = 0; i < 4; i++) laneIn[i] <= genChar(genMode, i, tGen - skew[i]);
    tGen++;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      nFail++;
      $display("FAIL watchdog expired: actual %0d expected below 20000", wd);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  task automatic atPhase(int ph);
    @(negedge clk);
    while (tGen % 32 != ph) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) check(laneOut[i] == '0, "R1", "lane in reset", laneOut[i], 0);
    check(!aligned && !deskewErr, "R1", "flags in reset", {aligned, deskewErr}, 0);
    rstN = 1'b1;

    // R3 / R5: plain mode, align markers
    alTag = "R3";
    repeat (100) @(negedge clk);
    check(aligned, "R5", "aligned after columns", aligned, 1);
    check(aCols > 0, "R3", "align columns leave together", aCols, 1);
    atPhase(20);
    skew = '{1, 0, 4, 7};
    aCols = 0;
    alTag = "R5";
    repeat (100) @(negedge clk);
    check(aligned && aCols > 0, "R5", "realigned on new skew", aCols, 1);

    // R8: skew beyond span
    atPhase(20);
    skew = '{0, 12, 0, 0};
    alTag = "R8";
    repeat (100) @(negedge clk);
    check(errPulses > 0, "R8", "error pulses", errPulses, 1);
    check(!aligned, "R8", "aligned after error", aligned, 0);

    // R6: hysteresis, calEn ignored
    atPhase(20);
    skew = '{0, 2, 5, 3};
    smEn = 1'b1;
    alTag = "R6";
    repeat (70) @(negedge clk);
    check(!aligned, "R6", "not aligned after 2 columns", aligned, 0);
    repeat (130) @(negedge clk);
    check(aligned, "R6", "aligned after 4 columns", aligned, 1);

    // R7: bad columns while aligned
    atPhase(20);
    skew = '{3, 0, 1, 6};
    falls = 0;
    alTag = "R7";
    repeat (64) @(negedge clk);
    check(aligned, "R7", "held through 2 bad columns", aligned, 1);
    repeat (240) @(negedge clk);
    check(falls > 0, "R7", "dropped after 4 bad", falls, 1);
    check(aligned, "R7", "reacquired", aligned, 1);

    // R9: lane fault
    alTag = "R9";
    laneOk = 4'b1011;
    repeat (2) @(negedge clk);
    check(!aligned, "R9", "aligned under fault", aligned, 0);
    repeat (40) @(negedge clk);
    laneOk = 4'hF;
    repeat (160) @(negedge clk);
    check(aligned, "R9", "recovered after fault", aligned, 1);

    // R10: codec off and rate mismatch
    alTag = "R10";
    codecOn = 1'b0;
    repeat (2) @(negedge clk);
    check(!aligned, "R10", "aligned with codec off", aligned, 0);
    repeat (40) @(negedge clk);
    codecOn = 1'b1;
    smEn = 1'b0;
    repeat (40) @(negedge clk);
    check(aligned, "R10", "aligned with codec back", aligned, 1);
    laneRate = 4'b0010;
    repeat (2) @(negedge clk);
    check(!aligned, "R10", "aligned with rate mismatch", aligned, 0);
    repeat (64) @(negedge clk);
    check(!aligned, "R10", "stays low with mismatch", aligned, 0);
    laneRate = 4'h0;

    // R4: idle-to-data boundary, lane 0 start
    atPhase(20);
    markSel = 1'b1;
    genMode = 1;
    skew = '{0, 3, 1, 6};
    sCols = 0;
    alTag = "R4";
    repeat (100) @(negedge clk);
    check(aligned, "R4", "aligned on boundary", aligned, 1);
    check(sCols > 0, "R4", "start column leaves together", sCols, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule